// File: doc/BRIEF.md
# Return Address Stack with Error Flags

This block holds the return addresses of a processor core in a sixteen-layer hardware stack of 14-bit entries. A call or an accepted interrupt pushes the current program counter. A return sends the top entry back to the core as a redirect target and then drops it. A discard command drops the top entry without redirecting. A 5-bit pointer counts the occupied layers. At zero the stack is empty and the top-of-stack output reads 0.

The block watches its own limits. A full flag warns when the last layer is in use. A push onto a full stack sets an overflow flag and replaces the top entry in place. A return from an empty stack sets an underflow flag and sends the core to address 0. A build-time option turns either error into a one-cycle reset request. The reset request also sets a sticky error flag.

The system reset controller answers the request with a soft reset. The soft reset empties the stack and clears the overflow and underflow flags, but keeps the error flag. Software clears flags with a write-one-to-clear mask, and a power-on reset clears everything.

Top module: `ret_addr_stack`

## Requirements
- R1: After power-on reset the pointer is 0, the top-of-stack output is 0, and full, overflow, underflow, error and the reset request are all 0.
- R2: A push below the top layer increments the pointer, and from the next cycle the top-of-stack output shows the pushed address.
- R3: A return with a non-zero pointer raises the redirect output in the same cycle, with the current top entry as the redirect address. From the next cycle the pointer is one lower and the top-of-stack output shows the entry below.
- R4: A discard with a non-zero pointer decrements the pointer and exposes the entry below. It does not raise the redirect output.
- R5: A discard with the pointer at 0 leaves the pointer at 0 and does not set the underflow flag.
- R6: The full output is 1 exactly when the pointer equals 16, and the pointer never exceeds 16.
- R7: A push with the pointer at 16 sets the overflow flag, keeps the pointer at 16 and replaces the top entry with the pushed address. All lower layers keep their contents.
- R8: A return with the pointer at 0 raises the redirect output with address 0, sets the underflow flag and keeps the pointer at 0.
- R9: With the error-reset option set, an overflow or underflow event raises the reset request for exactly one cycle, starting the cycle after the event, and sets the error flag at the same edge.
- R10: With the error-reset option clear, overflow and underflow set their own flags but never raise the reset request or the error flag.
- R11: The soft reset input zeroes the pointer, the overflow flag, the underflow flag and the reset request, and leaves the error flag as it was. Only power-on reset or a software clear resets the error flag.
- R12: A flag clear write clears each flag whose mask bit is 1: bit 0 is overflow, bit 1 is underflow and bit 2 is error. If a flag is set and cleared in the same cycle, the set wins.
- R13: When commands coincide, push takes precedence over return, and return takes precedence over discard. Only the winning command acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| srst_i | input | 1 | Soft reset from the system reset controller, synchronous, active high |
| push_i | input | 1 | Call or accepted interrupt: push pc_i |
| ret_i | input | 1 | Return: redirect to the top entry and drop it |
| pop_i | input | 1 | Discard the top entry |
| pc_i | input | 14 | Address to push |
| clr_en_i | input | 1 | Flag clear write strobe |
| clr_mask_i | input | 3 | Clear mask: bit 0 overflow, bit 1 underflow, bit 2 error |
| tos_o | output | 14 | Top-of-stack entry, 0 when empty |
| ptr_o | output | 5 | Stack pointer (0 to 16) |
| full_o | output | 1 | Last layer occupied |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| err_o | output | 1 | Sticky error flag |
| redirect_o | output | 1 | PC redirect request, same cycle as the return |
| redirect_pc_o | output | 14 | Redirect target address |
| rst_req_o | output | 1 | One-cycle reset request after a stack error |

## Verification
The stack is driven with three input patterns:
- Short push, return and discard sequences with distinct addresses. These separate a correct pointer step from an off-by-one layer index or a stale top entry.
- A fill to sixteen layers followed by one more push, then a discard. This shows whether overflow overwrites only the top layer and whether the pointer holds.
- Returns and discards on an empty stack, together with coinciding commands. These separate underflow from a harmless empty discard and confirm the command precedence.

Two copies of the block, one with the error-reset option set and one with it clear, receive the same stimulus. This tells apart flag-only handling from a reset request that leaves the sticky error flag standing through a soft reset.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_PUSH = 2'd1,
        CMD_RET  = 2'd2,
        CMD_POP  = 2'd3
    } ras_cmd_e;

    // error events raised by the pointer logic in one cycle
    typedef struct packed {
        logic ovf;
        logic unf;
    } ras_err_t;

    // flag clear mask layout: bit 2 error, bit 1 underflow, bit 0 overflow
    typedef struct packed {
        logic err;
        logic unf;
        logic ovf;
    } ras_clr_t;

    // push beats return, return beats discard
    function automatic ras_cmd_e pick_cmd(input logic push, input logic ret, input logic pop);
        if (push) return CMD_PUSH;
        if (ret)  return CMD_RET;
        if (pop)  return CMD_POP;
        return CMD_IDLE;
    endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input  logic          clk_i,
    input  logic          por_i,
    input  logic          srst_i,
    input  ras_cmd_e      cmd_i,
    output logic [PW-1:0] ptr_o,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o,
    output ras_err_t      ev_o
);
    localparam logic [PW-1:0] TOP = PW'(DEPTH);

    logic [PW-1:0] ptr_q, ptr_d;
    logic          empty, at_top;

    always_comb begin
        empty    = (ptr_q == '0);
        at_top   = (ptr_q == TOP);
        ptr_d    = ptr_q;
        wr_en_o  = 1'b0;
        wr_idx_o = ptr_q;
        ev_o     = '0;
        case (cmd_i)
            CMD_PUSH: begin
                wr_en_o = 1'b1;
                if (at_top) begin
                    ev_o.ovf = 1'b1;           // top layer is overwritten in place
                end else begin
                    ptr_d    = ptr_q + 1'b1;
                    wr_idx_o = ptr_q + 1'b1;
                end
            end
            CMD_RET: begin
                if (empty) ev_o.unf = 1'b1;
                else       ptr_d    = ptr_q - 1'b1;
            end
            CMD_POP: begin
                if (!empty) ptr_d = ptr_q - 1'b1;
            end
            default: ;
        endcase
        if (srst_i) begin
            wr_en_o = 1'b0;
            ev_o    = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (por_i || srst_i) ptr_q <= '0;
        else                 ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int AW    = 14,
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input  logic          clk_i,
    input  logic          por_i,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [AW-1:0] rd_data_o
);
    // layer n is held at index n, so the pointer addresses it directly
    logic [AW-1:0] layers [1:DEPTH];

    for (genvar g = 1; g <= DEPTH; g++) begin : g_layer
        logic [AW-1:0] q;
        always_ff @(posedge clk_i) begin
            if (por_i)                                    q <= '0;
            else if (wr_en_i && (wr_idx_i == PW'(g)))     q <= wr_data_i;
        end
        assign layers[g] = q;
    end

    // index 0 selects nothing and reads as zero
    always_comb begin
        rd_data_o = '0;
        for (int i = 1; i <= DEPTH; i++) begin
            if (rd_idx_i == PW'(i)) rd_data_o = layers[i];
        end
    end

endmodule

// File: rtl/ras_flags.sv
module ras_flags
    import ras_pkg::*;
#(
    parameter bit ERR_RESET = 1'b1
) (
    input  logic     clk_i,
    input  logic     por_i,
    input  logic     srst_i,
    input  ras_err_t ev_i,
    input  logic     clr_en_i,
    input  ras_clr_t clr_mask_i,
    output logic     ovf_o,
    output logic     unf_o,
    output logic     err_o,
    output logic     rst_req_o
);
    logic     any_ev, raise;
    ras_clr_t clr;

    assign any_ev = ev_i.ovf | ev_i.unf;
    assign raise  = ERR_RESET && any_ev;
    assign clr    = clr_en_i ? clr_mask_i : '0;

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            ovf_o     <= 1'b0;
            unf_o     <= 1'b0;
            err_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else if (srst_i) begin
            // error flag survives the reset it caused
            ovf_o     <= 1'b0;
            unf_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            ovf_o     <= ev_i.ovf | (ovf_o & ~clr.ovf);
            unf_o     <= ev_i.unf | (unf_o & ~clr.unf);
            err_o     <= raise    | (err_o & ~clr.err);
            rst_req_o <= raise;
        end
    end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int  AW        = 14,
    parameter int  DEPTH     = 16,
    parameter bit  ERR_RESET = 1'b1,
    localparam int PW        = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          por_i,
    input  logic          srst_i,
    input  logic          push_i,
    input  logic          ret_i,
    input  logic          pop_i,
    input  logic [AW-1:0] pc_i,
    input  logic          clr_en_i,
    input  logic [2:0]    clr_mask_i,
    output logic [AW-1:0] tos_o,
    output logic [PW-1:0] ptr_o,
    output logic          full_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          err_o,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_pc_o,
    output logic          rst_req_o
);
    ras_cmd_e      cmd;
    ras_err_t      ev;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] ptr;
    logic [AW-1:0] top_entry;

    assign cmd = pick_cmd(push_i, ret_i, pop_i);

    ras_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
        .clk_i    (clk_i),
        .por_i    (por_i),
        .srst_i   (srst_i),
        .cmd_i    (cmd),
        .ptr_o    (ptr),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .ev_o     (ev)
    );

    ras_store #(.AW(AW), .DEPTH(DEPTH), .PW(PW)) u_store (
        .clk_i     (clk_i),
        .por_i     (por_i),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (pc_i),
        .rd_idx_i  (ptr),
        .rd_data_o (top_entry)
    );

    ras_flags #(.ERR_RESET(ERR_RESET)) u_flags (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .srst_i     (srst_i),
        .ev_i       (ev),
        .clr_en_i   (clr_en_i),
        .clr_mask_i (ras_clr_t'(clr_mask_i)),
        .ovf_o      (ovf_o),
        .unf_o      (unf_o),
        .err_o      (err_o),
        .rst_req_o  (rst_req_o)
    );

    assign tos_o         = top_entry;
    assign ptr_o         = ptr;
    assign full_o        = (ptr == PW'(DEPTH));
    // the top entry is read out before the pointer moves; empty reads 0
    assign redirect_o    = (cmd == CMD_RET) && !srst_i && !por_i;
    assign redirect_pc_o = top_entry;

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int  AW        = 14,
    parameter int  DEPTH     = 16,
    parameter bit  ERR_RESET = 1'b1,
    localparam int PW        = $clog2(DEPTH + 1)
) (
    input logic          clk_i,
    input logic          por_i,
    input logic          srst_i,
    input logic          push_i,
    input logic          ret_i,
    input logic          pop_i,
    input logic [AW-1:0] pc_i,
    input logic [AW-1:0] tos_o,
    input logic [PW-1:0] ptr_o,
    input logic          full_o,
    input logic          ovf_o,
    input logic          unf_o,
    input logic          err_o,
    input logic          redirect_o,
    input logic [AW-1:0] redirect_pc_o,
    input logic          rst_req_o
);
    p_ptr_range_r6: assert property (@(posedge clk_i) disable iff (por_i)
        ptr_o <= PW'(DEPTH));

    p_push_step_r2: assert property (@(posedge clk_i) disable iff (por_i)
        (push_i && !srst_i && !full_o) |=> (ptr_o == PW'($past(ptr_o) + 1'b1)));

    p_push_top_r2: assert property (@(posedge clk_i) disable iff (por_i)
        (push_i && !srst_i) |=> (tos_o == $past(pc_i)));

    p_no_overflow_move_r7: assert property (@(posedge clk_i) disable iff (por_i)
        (push_i && !srst_i && full_o) |=> (ptr_o == PW'(DEPTH)) && ovf_o);

    p_underflow_zero_r8: assert property (@(posedge clk_i) disable iff (por_i)
        (ret_i && !push_i && !srst_i && ptr_o == '0) |-> (redirect_o && redirect_pc_o == '0));

    p_pop_empty_r5: assert property (@(posedge clk_i) disable iff (por_i)
        (pop_i && !push_i && !ret_i && !srst_i && ptr_o == '0) |=> (ptr_o == '0));

    p_req_has_err_r9: assert property (@(posedge clk_i) disable iff (por_i)
        rst_req_o |-> err_o);

    p_no_req_r10: assert property (@(posedge clk_i) disable iff (por_i)
        !ERR_RESET |-> (!rst_req_o && !err_o));

    p_soft_reset_r11: assert property (@(posedge clk_i) disable iff (por_i)
        srst_i |=> (ptr_o == '0 && !ovf_o && !unf_o && !rst_req_o));

endmodule

bind ret_addr_stack ras_checker #(
    .AW        (AW),
    .DEPTH     (DEPTH),
    .ERR_RESET (ERR_RESET)
) i_ras_checker (.*);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;

    logic        clk = 1'b0;
    logic        por = 1'b1, srst = 1'b0;
    logic        push = 1'b0, ret = 1'b0, pop = 1'b0;
    logic [13:0] pc = '0;
    logic        clr_en = 1'b0;
    logic [2:0]  clr_mask = '0;

    logic [13:0] tos, rpc, tos_n, rpc_n;
    logic [4:0]  ptr, ptr_n;
    logic        full, ovf, unf, err, redir, rreq;
    logic        full_n, ovf_n, unf_n, err_n, redir_n, rreq_n;

    logic        redir_s;
    logic [13:0] rpc_s;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ret_addr_stack #(.ERR_RESET(1'b1)) i_ret_addr_stack (
        .clk_i(clk), .por_i(por), .srst_i(srst), .push_i(push), .ret_i(ret), .pop_i(pop),
        .pc_i(pc), .clr_en_i(clr_en), .clr_mask_i(clr_mask), .tos_o(tos), .ptr_o(ptr),
        .full_o(full), .ovf_o(ovf), .unf_o(unf), .err_o(err), .redirect_o(redir),
        .redirect_pc_o(rpc), .rst_req_o(rreq));

    ret_addr_stack #(.ERR_RESET(1'b0)) i_ret_addr_stack_nr (
        .clk_i(clk), .por_i(por), .srst_i(srst), .push_i(push), .ret_i(ret), .pop_i(pop),
        .pc_i(pc), .clr_en_i(clr_en), .clr_mask_i(clr_mask), .tos_o(tos_n), .ptr_o(ptr_n),
        .full_o(full_n), .ovf_o(ovf_n), .unf_o(unf_n), .err_o(err_n), .redirect_o(redir_n),
        .redirect_pc_o(rpc_n), .rst_req_o(rreq_n));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // apply one command for one clock; combinational redirect is captured before the edge
    task automatic cmd(input logic p, input logic r, input logic o, input logic [13:0] addr);
        push = p; ret = r; pop = o; pc = addr;
        #1;
        redir_s = redir;
        rpc_s   = rpc;
        @(posedge clk); #1;
        push = 1'b0; ret = 1'b0; pop = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic soft_reset();
        srst = 1'b1; @(posedge clk); #1; srst = 1'b0;
    endtask

    task automatic clear(input logic [2:0] m);
        clr_en = 1'b1; clr_mask = m; @(posedge clk); #1; clr_en = 1'b0; clr_mask = '0;
    endtask

    task automatic t_reset();
        por = 1'b1; repeat (2) @(posedge clk); #1; por = 1'b0;
        chk("R1 ptr", ptr, 0);
        chk("R1 tos", tos, 0);
        chk("R1 flags", {full, ovf, unf, err, rreq}, 0);
    endtask

    task automatic t_push_ret_pop();
        cmd(1, 0, 0, 14'h0100);
        cmd(1, 0, 0, 14'h2ABC);
        cmd(1, 0, 0, 14'h3FFF);
        chk("R2 ptr", ptr, 3);
        chk("R2 tos", tos, 14'h3FFF);
        cmd(0, 1, 0, 14'h0);
        chk("R3 redirect", redir_s, 1);
        chk("R3 redirect pc", rpc_s, 14'h3FFF);
        chk("R3 ptr", ptr, 2);
        chk("R3 tos", tos, 14'h2ABC);
        cmd(0, 0, 1, 14'h0);
        chk("R4 no redirect", redir_s, 0);
        chk("R4 ptr", ptr, 1);
        chk("R4 tos", tos, 14'h0100);
        cmd(0, 0, 1, 14'h0);
        chk("R4 ptr empty", ptr, 0);
        chk("R4 tos empty", tos, 0);
        cmd(0, 0, 1, 14'h0);
        chk("R5 ptr", ptr, 0);
        chk("R5 unf", unf, 0);
    endtask

    task automatic t_full_overflow();
        for (int i = 1; i <= 16; i++) begin
            cmd(1, 0, 0, 14'(14'h0100 + i));
            if (i == 15) chk("R6 not full at 15", full, 0);
        end
        chk("R6 full", full, 1);
        chk("R6 ptr", ptr, 16);
        chk("R6 tos", tos, 14'h0110);
        chk("R6 ovf before", ovf, 0);
        cmd(1, 0, 0, 14'h2222);
        chk("R7 ovf", ovf, 1);
        chk("R7 ptr", ptr, 16);
        chk("R7 tos", tos, 14'h2222);
        chk("R9 rst_req", rreq, 1);
        chk("R9 err", err, 1);
        chk("R10 ovf", ovf_n, 1);
        chk("R10 rst_req", rreq_n, 0);
        chk("R10 err", err_n, 0);
        idle();
        chk("R9 rst_req one cycle", rreq, 0);
        cmd(0, 0, 1, 14'h0);
        chk("R7 lower layer kept", tos, 14'h010F);
        chk("R7 ptr after pop", ptr, 15);
        soft_reset();
        chk("R11 ptr", ptr, 0);
        chk("R11 ovf", ovf, 0);
        chk("R11 err kept", err, 1);
        clear(3'b100);
        chk("R12 err cleared", err, 0);
    endtask

    task automatic t_underflow();
        cmd(0, 1, 0, 14'h1555);
        chk("R8 redirect", redir_s, 1);
        chk("R8 redirect pc", rpc_s, 0);
        chk("R8 unf", unf, 1);
        chk("R8 ptr", ptr, 0);
        chk("R9 rst_req on unf", rreq, 1);
        chk("R10 unf", unf_n, 1);
        chk("R10 no rst_req", rreq_n, 0);
        clear(3'b010);
        chk("R12 unf cleared", unf, 0);
        chk("R12 err untouched", err, 1);
        chk("R12 unf cleared nr", unf_n, 0);
        clr_en = 1'b1; clr_mask = 3'b010;
        cmd(0, 1, 0, 14'h0);
        clr_en = 1'b0; clr_mask = '0;
        chk("R12 set wins", unf, 1);
        soft_reset();
    endtask

    task automatic t_priority();
        cmd(1, 0, 1, 14'h0AAA);
        chk("R13 push over pop ptr", ptr, 1);
        chk("R13 push over pop tos", tos, 14'h0AAA);
        cmd(1, 1, 0, 14'h0BBB);
        chk("R13 push over ret redirect", redir_s, 0);
        chk("R13 push over ret ptr", ptr, 2);
        cmd(0, 1, 1, 14'h0);
        chk("R13 ret over pop redirect", redir_s, 1);
        chk("R13 ret over pop pc", rpc_s, 14'h0BBB);
        chk("R13 ret over pop ptr", ptr, 1);
    endtask

    task automatic t_por_clears_err();
        cmd(0, 0, 0, 14'h0);
        chk("R11 err before por", err, 1);
        por = 1'b1; idle(); por = 1'b0;
        chk("R11 por clears err", err, 0);
        chk("R1 por ptr", ptr, 0);
    endtask

    initial begin
        t_reset();
        t_push_ret_pop();
        t_full_overflow();
        t_underflow();
        t_priority();
        t_por_clears_err();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule